// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a console's 13-bit cartridge address bus and the 16-bit address bus shared by the flash and RAM on a flash cartridge. The console sees only a 4 KB window. The mapper widens each console access into a flash address by adding bank bits. It picks those bits in one of two ways. Three hotspot schemes change the bank when the console touches one of a few addresses near the top of the window. A data-line scheme takes the bank number from the data lines during a write to a small low region. In that scheme the upper half of the window is fixed to the last 2 KB of flash.

The scheme is chosen by a static select input and is sampled during reset. The cartridge address is registered. It changes only on cartridge-space accesses, and it appears one clock after the access is presented. The lowest seven address bits are copied through unchanged, because no scheme switches anything smaller than 128 bytes.

A programming mode lets an external microcontroller take over the wide bus. It shifts a 16-bit address in serially, most significant bit first, and then pulses a load strobe. That address then drives the output, and console traffic is ignored.

Top module: `bmap_cart_mapper`

## Requirements
- R1: While reset is high, `cart_addr` is 0x0000. The reset value of the bank register depends on the scheme present on `scheme_sel` during reset. Outside programming mode, `cart_addr` changes only in the clock cycle after an access with `acc_valid` = 1 and `con_addr[12]` = 1.
- R2: After any mapped access, `cart_addr[6:0]` equals `con_addr[6:0]` of that access.
- R3: With `scheme_sel` = 0 (two 4 KB banks), an access to 0x1FF8 selects bank 0 and an access to 0x1FF9 selects bank 1. The reset bank is 1. The flash address is bank*4096 + `con_addr[11:0]`.
- R4: With `scheme_sel` = 1 (four 4 KB banks), addresses 0x1FF6 through 0x1FF9 select banks 0 through 3. The reset bank is 3. Neighbouring addresses such as 0x1FF5 and 0x1FFA switch nothing.
- R5: With `scheme_sel` = 2 (eight 4 KB banks), addresses 0x1FF4 through 0x1FFB select banks 0 through 7. The reset bank is 7. The bank register never holds a value outside the range of the active hotspot scheme.
- R6: A hotspot access is itself mapped through the old bank. The new bank applies from the next access onward.
- R7: A console access with `con_addr[12]` = 0 leaves `cart_addr` unchanged, and it never switches a hotspot bank, even at an address such as 0x0FF8.
- R8: With `scheme_sel` = 3, a write (`acc_write` = 1) with `con_addr[12]` = 0 and `con_addr` <= 0x3F latches `con_data[3:0]` as the bank. Reads at those addresses and writes above 0x3F leave the bank unchanged.
- R9: With `scheme_sel` = 3, a cartridge access with `con_addr[11]` = 0 maps to bank*2048 + `con_addr[10:0]`. An access with `con_addr[11]` = 1 maps to 0xF800 + `con_addr[10:0]`. The reset bank is 0.
- R10: While `prog_mode` = 1, each cycle with `ser_shift` = 1 shifts `ser_bit` in, most significant bit first. `cart_addr` stays unchanged until `ser_load` is pulsed. After the pulse, `cart_addr` equals the shifted 16-bit word one clock later.
- R11: While `prog_mode` = 1, console accesses change neither `cart_addr` nor the bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scheme_sel | input | 2 | Mapping scheme: 0, 1 or 2 selects hotspot 8K, 16K or 32K; 3 selects the data-line scheme |
| acc_valid | input | 1 | One console access is presented this cycle |
| acc_write | input | 1 | The access is a write |
| con_addr | input | 13 | Console address A0..A12 |
| con_data | input | 4 | Console data D0..D3 |
| prog_mode | input | 1 | Programming mode; the serial address owns the output |
| ser_shift | input | 1 | Shift `ser_bit` into the serial register |
| ser_bit | input | 1 | Serial address bit, MSB first |
| ser_load | input | 1 | Transfer the serial register to the output |
| cart_addr | output | 16 | Registered flash/RAM address |

## Verification
Several rules are checked on every clock cycle: the seven low bits are copied through, the output holds on non-cartridge accesses, the output freezes in programming mode until a load and then takes the serial word, the upper data-line window is fixed, and the hotspot bank stays in range. Other behaviour can only be shown by the bench's access sequences, checked against its own mapping model. That covers which exact addresses switch banks and which neighbours do not, the one-access delay before a new bank applies, the scheme-dependent reset banks, the data-line latch conditions, and the bank surviving console traffic during programming mode.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

  typedef enum logic [1:0] {
    SCH_HOT8K    = 2'd0,
    SCH_HOT16K   = 2'd1,
    SCH_HOT32K   = 2'd2,
    SCH_DATALINE = 2'd3
  } scheme_e;

  // First hotspot address of each hotspot scheme
  function automatic logic [15:0] hot_base(scheme_e s);
    case (s)
      SCH_HOT8K:  return 16'h1FF8;
      SCH_HOT16K: return 16'h1FF6;
      default:    return 16'h1FF4;
    endcase
  endfunction

  // Number of 4 KB banks of each hotspot scheme (0 for the data-line scheme)
  function automatic logic [3:0] hot_count(scheme_e s);
    case (s)
      SCH_HOT8K:  return 4'd2;
      SCH_HOT16K: return 4'd4;
      SCH_HOT32K: return 4'd8;
      default:    return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/bmap_switch_dec.sv
module bmap_switch_dec
  import bmap_pkg::*;
#(
  parameter int CON_AW  = 13,
  parameter int BANK_W  = 4,
  parameter int DL_LAST = 63
) (
  input  scheme_e             scheme,
  input  logic [CON_AW-1:0]   addr,
  input  logic                wr,
  input  logic [BANK_W-1:0]   data,
  output logic                hit,
  output logic [BANK_W-1:0]   new_bank
);
  localparam logic [CON_AW-1:0] DL_LIMIT = CON_AW'(DL_LAST);

  logic [CON_AW-1:0] base;
  logic [CON_AW-1:0] offs;
  logic [CON_AW-1:0] count;

  always_comb begin
    base  = CON_AW'(hot_base(scheme));
    count = CON_AW'(hot_count(scheme));
    offs  = addr - base;
    hit      = 1'b0;
    new_bank = '0;
    if (scheme == SCH_DATALINE) begin
      if (wr && !addr[CON_AW-1] && (addr <= DL_LIMIT)) begin
        hit      = 1'b1;
        new_bank = data;
      end
    end else if (addr[CON_AW-1] && (addr >= base) && (offs < count)) begin
      hit      = 1'b1;
      new_bank = offs[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/bmap_bank_reg.sv
module bmap_bank_reg
  import bmap_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  scheme_e           scheme,
  input  logic              upd,
  input  logic [BANK_W-1:0] nb,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] rst_bank;

  always_comb begin
    if (scheme == SCH_DATALINE) rst_bank = '0;
    else                        rst_bank = BANK_W'(hot_count(scheme) - 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst)      bank <= rst_bank;
    else if (upd) bank <= nb;
  end

  AST_HOT_BANK_RANGE: assert property (@(posedge clk) disable iff (rst)
    (scheme != SCH_DATALINE) |-> (bank < BANK_W'(hot_count(scheme)))); // R5
endmodule

// File: rtl/bmap_ser_shift.sv
module bmap_ser_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/bmap_cart_mapper.sv
module bmap_cart_mapper
  import bmap_pkg::*;
#(
  parameter int CON_AW  = 13,
  parameter int CART_AW = 16,
  parameter int BANK_W  = 4,
  parameter int PASS_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         scheme_sel,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [CON_AW-1:0]  con_addr,
  input  logic [BANK_W-1:0]  con_data,
  input  logic               prog_mode,
  input  logic               ser_shift,
  input  logic               ser_bit,
  input  logic               ser_load,
  output logic [CART_AW-1:0] cart_addr
);
  localparam int WIN_HOT = CON_AW - 1;   // 4 KB hotspot window offset width
  localparam int WIN_DL  = CON_AW - 2;   // 2 KB data-line window offset width

  scheme_e             scheme;
  logic                sw_hit;
  logic [BANK_W-1:0]   sw_bank;
  logic [BANK_W-1:0]   bank;
  logic [CART_AW-1:0]  ser_word;
  logic [CART_AW-1:0]  mapped;
  logic                con_live;

  assign scheme   = scheme_e'(scheme_sel);
  assign con_live = acc_valid && !prog_mode;

  bmap_switch_dec #(.CON_AW(CON_AW), .BANK_W(BANK_W)) i_dec (
    .scheme(scheme), .addr(con_addr), .wr(acc_write), .data(con_data),
    .hit(sw_hit), .new_bank(sw_bank)
  );

  bmap_bank_reg #(.BANK_W(BANK_W)) i_bank (
    .clk(clk), .rst(rst), .scheme(scheme),
    .upd(con_live && sw_hit), .nb(sw_bank), .bank(bank)
  );

  bmap_ser_shift #(.W(CART_AW)) i_ser (
    .clk(clk), .rst(rst), .shift_en(prog_mode && ser_shift),
    .bit_in(ser_bit), .word(ser_word)
  );

  always_comb begin
    mapped = '0;
    if (scheme == SCH_DATALINE) begin
      mapped[WIN_DL-1:0] = con_addr[WIN_DL-1:0];
      if (con_addr[WIN_DL]) mapped[CART_AW-1:WIN_DL] = '1;
      else                  mapped[WIN_DL +: BANK_W] = bank;
    end else begin
      mapped[WIN_HOT-1:0]       = con_addr[WIN_HOT-1:0];
      mapped[WIN_HOT +: BANK_W] = bank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cart_addr <= '0;
    end else if (prog_mode) begin
      if (ser_load) cart_addr <= ser_word;
    end else if (acc_valid && con_addr[CON_AW-1]) begin
      cart_addr <= mapped;
    end
  end

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
    (con_live && con_addr[CON_AW-1]) |=>
      (cart_addr[PASS_W-1:0] == $past(con_addr[PASS_W-1:0]))); // R2

  AST_NONCART_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!prog_mode && !(acc_valid && con_addr[CON_AW-1])) |=> $stable(cart_addr)); // R7

  AST_DL_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (con_live && con_addr[CON_AW-1] && con_addr[WIN_DL] && scheme == SCH_DATALINE) |=>
      (cart_addr[CART_AW-1:WIN_DL] == '1)); // R9

  AST_PROG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (prog_mode && ser_load) |=> (cart_addr == $past(ser_word))); // R10

  AST_PROG_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (prog_mode && !ser_load) |=> $stable(cart_addr)); // R11
endmodule

// File: tb/test_bmap_cart_mapper.sv
module test_bmap_cart_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  scheme_sel = 2'd0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [12:0] con_addr = '0;
  logic [3:0]  con_data = '0;
  logic        prog_mode = 1'b0;
  logic        ser_shift = 1'b0;
  logic        ser_bit = 1'b0;
  logic        ser_load = 1'b0;
  logic [15:0] cart_addr;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bmap_cart_mapper i_bmap_cart_mapper (
    .clk(clk), .rst(rst), .scheme_sel(scheme_sel), .acc_valid(acc_valid),
    .acc_write(acc_write), .con_addr(con_addr), .con_data(con_data),
    .prog_mode(prog_mode), .ser_shift(ser_shift), .ser_bit(ser_bit),
    .ser_load(ser_load), .cart_addr(cart_addr)
  );

  // Reference model state
  logic [1:0]  m_sch;
  logic [3:0]  m_bank;
  logic [15:0] m_out;

  // {reset_first, scheme, write, addr[12:0], data[7:0]}
  localparam int NV = 32;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 13'h1000, 8'h0},  // R3 reset bank 1
    {1'b0, 2'd0, 1'b0, 13'h1FF8, 8'h0},  // R6 old bank maps hotspot
    {1'b0, 2'd0, 1'b0, 13'h1234, 8'h0},
    {1'b0, 2'd0, 1'b0, 13'h0FF9, 8'h0},  // R7 no switch, hold
    {1'b0, 2'd0, 1'b0, 13'h1055, 8'h0},
    {1'b0, 2'd0, 1'b1, 13'h1FF9, 8'h0},
    {1'b0, 2'd0, 1'b0, 13'h1ABC, 8'h0},
    {1'b1, 2'd1, 1'b0, 13'h1100, 8'h0},  // R4 reset bank 3
    {1'b0, 2'd1, 1'b0, 13'h1FF6, 8'h0},
    {1'b0, 2'd1, 1'b0, 13'h1FFA, 8'h0},  // not a hotspot
    {1'b0, 2'd1, 1'b0, 13'h1FF5, 8'h0},  // not a hotspot
    {1'b0, 2'd1, 1'b0, 13'h1FF8, 8'h0},
    {1'b0, 2'd1, 1'b0, 13'h1001, 8'h0},
    {1'b1, 2'd2, 1'b0, 13'h1000, 8'h0},  // R5 reset bank 7
    {1'b0, 2'd2, 1'b0, 13'h1FF4, 8'h0},
    {1'b0, 2'd2, 1'b0, 13'h1FF9, 8'h0},
    {1'b0, 2'd2, 1'b0, 13'h1F00, 8'h0},
    {1'b0, 2'd2, 1'b0, 13'h1FFB, 8'h0},
    {1'b0, 2'd2, 1'b0, 13'h1FFC, 8'h0},  // past the range
    {1'b0, 2'd2, 1'b0, 13'h1010, 8'h0},
    {1'b1, 2'd3, 1'b0, 13'h1000, 8'h0},  // R9 reset bank 0
    {1'b0, 2'd3, 1'b1, 13'h003F, 8'h0A},
    {1'b0, 2'd3, 1'b0, 13'h1123, 8'h0},
    {1'b0, 2'd3, 1'b0, 13'h1923, 8'h0},
    {1'b0, 2'd3, 1'b1, 13'h0040, 8'h03}, // R8 above limit ignored
    {1'b0, 2'd3, 1'b0, 13'h1000, 8'h0},
    {1'b0, 2'd3, 1'b0, 13'h003F, 8'h05}, // R8 read ignored
    {1'b0, 2'd3, 1'b0, 13'h1001, 8'h0},
    {1'b0, 2'd3, 1'b1, 13'h0000, 8'h0F},
    {1'b0, 2'd3, 1'b0, 13'h1777, 8'h0},
    {1'b0, 2'd3, 1'b1, 13'h1FF8, 8'h02}, // cart-space write, no latch
    {1'b0, 2'd3, 1'b0, 13'h1456, 8'h0}
  };

  function automatic logic [15:0] ref_map(logic [1:0] s, logic [3:0] b, logic [12:0] a);
    if (s == 2'd3) begin
      if (a[11]) return 16'hF800 + 16'(a[10:0]);
      return (16'(b) * 16'd2048) + 16'(a[10:0]);
    end
    return (16'(b) * 16'd4096) + 16'(a[11:0]);
  endfunction

  function automatic int ref_base(logic [1:0] s);
    return (s == 2'd0) ? 'h1FF8 : (s == 2'd1) ? 'h1FF6 : 'h1FF4;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cart_addr got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] s);
    @(negedge clk);
    scheme_sel = s; rst = 1'b1; acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sch  = s;
    m_bank = (s == 2'd3) ? 4'd0 : 4'((2 << s) - 1);
    m_out  = 16'h0;
  endtask

  task automatic access(logic w, logic [12:0] a, logic [3:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; con_addr = a; con_data = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic model_step(logic w, logic [12:0] a, logic [3:0] d);
    int cnt;
    if (a[12]) m_out = ref_map(m_sch, m_bank, a);
    if (m_sch == 2'd3) begin
      if (w && !a[12] && a <= 13'h3F) m_bank = d;
    end else begin
      cnt = 2 << m_sch;
      if (int'(a) >= ref_base(m_sch) && int'(a) < ref_base(m_sch) + cnt)
        m_bank = 4'(int'(a) - ref_base(m_sch));
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] pword;
    // R1: reset value of the output
    do_reset(2'd0);
    check("R1", cart_addr, 16'h0000);

    // Table walk against the reference model
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      string tg;
      v = VEC[i];
      if (v[24]) do_reset(v[23:22]);
      access(v[21], v[20:8], v[3:0]);
      model_step(v[21], v[20:8], v[3:0]);
      if (!v[20]) tg = (v[23:22] == 2'd3) ? "R8" : "R7";
      else case (v[23:22])
        2'd0:    tg = "R3/R6";
        2'd1:    tg = "R4/R6";
        2'd2:    tg = "R5/R6";
        default: tg = "R9";
      endcase
      check(tg, cart_addr, m_out);
      if (v[20]) check("R2", {9'h0, cart_addr[6:0]}, {9'h0, v[14:8]});
    end

    // R10: serial load in programming mode
    do_reset(2'd0);
    pword = 16'hA5C3;
    @(negedge clk);
    prog_mode = 1'b1;
    for (int k = 15; k >= 0; k--) begin
      ser_shift = 1'b1; ser_bit = pword[k];
      @(negedge clk);
    end
    ser_shift = 1'b0;
    check("R10", cart_addr, 16'h0000);
    ser_load = 1'b1;
    @(negedge clk);
    ser_load = 1'b0;
    check("R10", cart_addr, 16'hA5C3);

    // R11: console traffic ignored while programming
    access(1'b0, 13'h1FF8, 4'h0);
    check("R11", cart_addr, 16'hA5C3);
    access(1'b0, 13'h1234, 4'h0);
    check("R11", cart_addr, 16'hA5C3);
    @(negedge clk);
    prog_mode = 1'b0;
    access(1'b0, 13'h1000, 4'h0);
    check("R11", cart_addr, 16'h1000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule